// File: doc/BRIEF.md
# Cache Line Preload Channel

This block is one channel of a preload engine. It walks a run of cache lines in external memory and asks for each one to be written into a single chosen way of a second-level cache. Software loads a virtual start position, a line count, a stride in bytes, a target way and two interrupt options while the channel is idle. It then drives the channel with three commands: START, STOP and CLEAR.

Before the first line, and again whenever the position moves into a new 4KB page, the channel sends the virtual page number to a translation agent. The agent answers with a physical page, a cacheable flag and a fault flag. The channel keeps no translation between requests. If the page is cacheable, each line becomes one fill request carrying the physical line address and the target way, held until the cache acknowledges it. A line that already sits in another way is handled entirely by the cache: the channel counts it as done and moves on. If the page is not cacheable, the lines are counted off one per cycle and no fill is issued.

STOP leaves a resumable position in the position and lines-left registers, so a later START carries on from there. A translation fault aborts the channel. Finishing the run raises a completion interrupt on either the secure or the non-secure line.

Top module: `lpc_chan`

## Requirements
- R1: `chan_status` encodes idle as 0, running as 1, error as 2 and complete as 3. After reset the status is idle, all three interrupt outputs are low, both request outputs are low, and `pos_addr` and `lines_left` are zero.
- R2: A command is valid for one cycle when `cmd_valid` is high. `cmd_op` 1 is START, 2 is STOP and 3 is CLEAR. START in idle with a nonzero line count gives running status and a translation request on the next cycle. START in idle with a zero line count gives complete status and the completion interrupt on the next cycle. START in running, error or complete status has no effect.
- R3: `cfg_wr` loads position, line count, stride, way and both interrupt options only in idle status. In any other status it is ignored and changes nothing that is visible at the ports.
- R4: A translation request is raised at the start of a run and again whenever the position moves into a different 4KB page. `xl_vpage` is the position with its low 12 bits dropped. The request and its page stay unchanged until `xl_rsp`.
- R5: In a cacheable page each line produces one fill request. `fill_addr` is the translated page followed by bits 11 down to 6 of the position, with the low 6 bits zero. `fill_way` is the 3-bit way field. Request and address stay unchanged until `fill_ack`, and a fill request is only seen in running status.
- R6: In a page reported non-cacheable no fill request is made. One line is retired on every cycle.
- R7: Each retired line adds the stride to `pos_addr` and lowers `lines_left` by one.
- R8: STOP in running status takes effect when the current line retires, or when the outstanding translation answers. The status then becomes idle, `pos_addr` holds the next line to move and `lines_left` holds the lines still to move. A later START translates again and resumes from that point.
- R9: A translation fault gives error status, and `pos_addr` keeps the faulting address. `irq_err` rises only when the error-interrupt option is set.
- R10: When the last line retires the status becomes complete. The completion interrupt goes to `irq_done_sec` when the secure option is set and to `irq_done_ns` otherwise. At most one of the two is ever high.
- R11: CLEAR moves error or complete status to idle and drops every interrupt output. It leaves `pos_addr` and `lines_left` unchanged. CLEAR has no effect in running status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load configuration (idle only) |
| cfg_addr | input | AW | Virtual start position |
| cfg_lines | input | CW | Number of lines to move |
| cfg_stride | input | SW | Byte step between lines |
| cfg_way | input | WAY_W | Target cache way |
| cfg_done_sec | input | 1 | Route completion interrupt to the secure output |
| cfg_err_irq_en | input | 1 | Enable the error interrupt |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 1 START, 2 STOP, 3 CLEAR |
| xl_req | output | 1 | Translation request |
| xl_vpage | output | AW-PAGE_BITS | Virtual page to translate |
| xl_rsp | input | 1 | Translation answer valid |
| xl_ppage | input | PAW-PAGE_BITS | Physical page |
| xl_cacheable | input | 1 | Page is cacheable |
| xl_fault | input | 1 | Translation fault |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | PAW | Physical line address |
| fill_way | output | WAY_W | Way to fill |
| fill_ack | input | 1 | Line fill accepted |
| chan_status | output | 2 | Channel status |
| pos_addr | output | AW | Next line position (saved position when stopped) |
| lines_left | output | CW | Lines still to move |
| irq_done_sec | output | 1 | Secure completion interrupt (level) |
| irq_done_ns | output | 1 | Non-secure completion interrupt (level) |
| irq_err | output | 1 | Error interrupt (level) |

## Verification
A wrong sequencing state shows at the ports within one cycle, as a request line that is high or low when it should not be. A wrongly held page or cacheable flag shows on the next fill address. A wrong position or count shows on the next retired line, and again after STOP as a saved point from which a resumed run ends at the wrong address. Interrupt routing errors appear in the cycle the run ends or aborts. Because the bench compares every port against a behavioural model on every cycle, each of these shows up at the first cycle where it differs.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

   typedef enum logic [1:0] {
      STAT_IDLE = 2'd0,
      STAT_RUN  = 2'd1,
      STAT_ERR  = 2'd2,
      STAT_DONE = 2'd3
   } chan_stat_e;

   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,
      OP_START = 2'd1,
      OP_STOP  = 2'd2,
      OP_CLEAR = 2'd3
   } chan_op_e;

   // Internal sequencing phase; the three running phases share one status.
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_XL   = 3'd1,
      PH_FILL = 3'd2,
      PH_SKIP = 3'd3,
      PH_ERR  = 3'd4,
      PH_DONE = 3'd5
   } chan_phase_e;

   function automatic logic phase_running(chan_phase_e ph);
      return (ph == PH_XL) || (ph == PH_FILL) || (ph == PH_SKIP);
   endfunction

   function automatic chan_stat_e phase_status(chan_phase_e ph);
      chan_stat_e s;
      case (ph)
         PH_XL, PH_FILL, PH_SKIP: s = STAT_RUN;
         PH_ERR:                  s = STAT_ERR;
         PH_DONE:                 s = STAT_DONE;
         default:                 s = STAT_IDLE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lpc_cmd_dec.sv
module lpc_cmd_dec
   import lpc_pkg::*;
(
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_op,
   input  logic        cfg_wr,
   input  chan_phase_e phase,
   output logic        do_start,
   output logic        do_stop,
   output logic        do_clear,
   output logic        do_cfg
);

   logic is_idle;
   logic is_run;
   logic is_final;

   assign is_idle  = (phase == PH_IDLE);
   assign is_run   = phase_running(phase);
   assign is_final = (phase == PH_ERR) || (phase == PH_DONE);

   // Each command is qualified by the status in which it is legal.
   assign do_start = cmd_valid && (cmd_op == OP_START) && is_idle;
   assign do_stop  = cmd_valid && (cmd_op == OP_STOP)  && is_run;
   assign do_clear = cmd_valid && (cmd_op == OP_CLEAR) && is_final;
   assign do_cfg   = cfg_wr && is_idle;

endmodule

// File: rtl/lpc_addr_step.sv
module lpc_addr_step #(
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int SW        = 16,
   parameter int PAGE_BITS = 12
) (
   input  logic [AW-1:0] cur_addr,
   input  logic [CW-1:0] cur_left,
   input  logic [SW-1:0] stride,
   output logic [AW-1:0] nxt_addr,
   output logic [CW-1:0] nxt_left,
   output logic          page_cross,
   output logic          last_line
);

   localparam int VPW = AW - PAGE_BITS;

   logic [VPW-1:0] cur_page;
   logic [VPW-1:0] nxt_page;

   generate
      if (SW < AW) begin : g_stride_zext
         assign nxt_addr = cur_addr + {{(AW-SW){1'b0}}, stride};
      end else begin : g_stride_trunc
         assign nxt_addr = cur_addr + stride[AW-1:0];
      end
   endgenerate

   assign nxt_left   = cur_left - CW'(1);
   assign cur_page   = cur_addr[AW-1:PAGE_BITS];
   assign nxt_page   = nxt_addr[AW-1:PAGE_BITS];
   assign page_cross = (cur_page != nxt_page);
   assign last_line  = (cur_left == CW'(1));

endmodule

// File: rtl/lpc_irq_ctl.sv
module lpc_irq_ctl #(
   parameter int N_DONE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_done,
   input  logic              set_err,
   input  logic              done_sec,
   input  logic              err_en,
   input  logic              clr,
   output logic [N_DONE-1:0] done_lines,
   output logic              err_line
);

   // Index 0 is the secure completion line, index 1 the non-secure one.
   generate
      for (genvar g = 0; g < N_DONE; g++) begin : g_done
         logic route_here;
         assign route_here = (g == 0) ? done_sec : !done_sec;
         always_ff @(posedge clk) begin
            if (!rst_n)
               done_lines[g] <= 1'b0;
            else if (clr)
               done_lines[g] <= 1'b0;
            else if (set_done && route_here)
               done_lines[g] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_line <= 1'b0;
      else if (clr)
         err_line <= 1'b0;
      else if (set_err && err_en)
         err_line <= 1'b1;
   end

endmodule

// File: rtl/lpc_chan.sv
module lpc_chan
   import lpc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int PAW       = 32,
   parameter int CW        = 16,
   parameter int SW        = 16,
   parameter int PAGE_BITS = 12,
   parameter int LINE_BITS = 6,
   parameter int WAY_W     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [AW-1:0]          cfg_addr,
   input  logic [CW-1:0]          cfg_lines,
   input  logic [SW-1:0]          cfg_stride,
   input  logic [WAY_W-1:0]       cfg_way,
   input  logic                   cfg_done_sec,
   input  logic                   cfg_err_irq_en,
   input  logic                   cmd_valid,
   input  logic [1:0]             cmd_op,
   output logic                   xl_req,
   output logic [AW-PAGE_BITS-1:0]  xl_vpage,
   input  logic                   xl_rsp,
   input  logic [PAW-PAGE_BITS-1:0] xl_ppage,
   input  logic                   xl_cacheable,
   input  logic                   xl_fault,
   output logic                   fill_req,
   output logic [PAW-1:0]         fill_addr,
   output logic [WAY_W-1:0]       fill_way,
   input  logic                   fill_ack,
   output logic [1:0]             chan_status,
   output logic [AW-1:0]          pos_addr,
   output logic [CW-1:0]          lines_left,
   output logic                   irq_done_sec,
   output logic                   irq_done_ns,
   output logic                   irq_err
);

   localparam int VPW = AW - PAGE_BITS;
   localparam int PPW = PAW - PAGE_BITS;
   localparam int OFW = PAGE_BITS - LINE_BITS;

   generate
      if (PAGE_BITS >= AW) begin : g_bad_aw
         $error("lpc_chan: AW must exceed PAGE_BITS");
      end
      if (PAGE_BITS >= PAW) begin : g_bad_paw
         $error("lpc_chan: PAW must exceed PAGE_BITS");
      end
      if (LINE_BITS >= PAGE_BITS) begin : g_bad_line
         $error("lpc_chan: a line must be smaller than a page");
      end
      if (CW < 1 || SW < 1 || WAY_W < 1) begin : g_bad_w
         $error("lpc_chan: counter, stride and way widths must be positive");
      end
   endgenerate

   chan_phase_e phase_q, phase_d;

   logic [AW-1:0]    addr_q;
   logic [CW-1:0]    left_q;
   logic [SW-1:0]    stride_q;
   logic [WAY_W-1:0] way_q;
   logic             sec_q;
   logic             erren_q;
   logic [PPW-1:0]   ppage_q;
   logic             cach_q;
   logic             stop_pend_q;

   logic do_start, do_stop, do_clear, do_cfg;
   logic [AW-1:0] nxt_addr;
   logic [CW-1:0] nxt_left;
   logic          page_cross;
   logic          last_line;
   logic          line_retire;
   logic          xl_take;
   logic          stop_now;
   logic          enter_done;
   logic          enter_err;
   logic [1:0]    done_lines;

   lpc_cmd_dec u_dec (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cfg_wr    (cfg_wr),
      .phase     (phase_q),
      .do_start  (do_start),
      .do_stop   (do_stop),
      .do_clear  (do_clear),
      .do_cfg    (do_cfg)
   );

   lpc_addr_step #(
      .AW        (AW),
      .CW        (CW),
      .SW        (SW),
      .PAGE_BITS (PAGE_BITS)
   ) u_step (
      .cur_addr   (addr_q),
      .cur_left   (left_q),
      .stride     (stride_q),
      .nxt_addr   (nxt_addr),
      .nxt_left   (nxt_left),
      .page_cross (page_cross),
      .last_line  (last_line)
   );

   // A line retires on its fill handshake, or every cycle when skipping.
   assign line_retire = ((phase_q == PH_FILL) && fill_ack) || (phase_q == PH_SKIP);
   assign xl_take     = (phase_q == PH_XL) && xl_rsp;
   assign stop_now    = stop_pend_q || do_stop;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (do_start)
               phase_d = (left_q == '0) ? PH_DONE : PH_XL;
         end
         PH_XL: begin
            if (xl_take) begin
               if (xl_fault)
                  phase_d = PH_ERR;
               else if (stop_now)
                  phase_d = PH_IDLE;
               else
                  phase_d = xl_cacheable ? PH_FILL : PH_SKIP;
            end
         end
         PH_FILL, PH_SKIP: begin
            if (line_retire) begin
               if (last_line)
                  phase_d = PH_DONE;
               else if (stop_now)
                  phase_d = PH_IDLE;
               else if (page_cross)
                  phase_d = PH_XL;
            end
         end
         PH_ERR, PH_DONE: begin
            if (do_clear)
               phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   assign enter_done = (phase_d == PH_DONE) && (phase_q != PH_DONE);
   assign enter_err  = (phase_d == PH_ERR)  && (phase_q != PH_ERR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         addr_q      <= '0;
         left_q      <= '0;
         stride_q    <= '0;
         way_q       <= '0;
         sec_q       <= 1'b0;
         erren_q     <= 1'b0;
         ppage_q     <= '0;
         cach_q      <= 1'b0;
         stop_pend_q <= 1'b0;
      end else begin
         phase_q     <= phase_d;
         stop_pend_q <= stop_now && phase_running(phase_d);
         if (do_cfg) begin
            addr_q   <= cfg_addr;
            left_q   <= cfg_lines;
            stride_q <= cfg_stride;
            way_q    <= cfg_way;
            sec_q    <= cfg_done_sec;
            erren_q  <= cfg_err_irq_en;
         end
         if (xl_take && !xl_fault) begin
            ppage_q <= xl_ppage;
            cach_q  <= xl_cacheable;
         end
         if (line_retire) begin
            addr_q <= nxt_addr;
            left_q <= nxt_left;
         end
      end
   end

   lpc_irq_ctl #(
      .N_DONE (2)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_done   (enter_done),
      .set_err    (enter_err),
      .done_sec   (sec_q),
      .err_en     (erren_q),
      .clr        (do_clear),
      .done_lines (done_lines),
      .err_line   (irq_err)
   );

   assign irq_done_sec = done_lines[0];
   assign irq_done_ns  = done_lines[1];

   assign xl_req      = (phase_q == PH_XL);
   assign xl_vpage    = addr_q[AW-1:PAGE_BITS];
   assign fill_req    = (phase_q == PH_FILL) && cach_q;
   assign fill_addr   = {ppage_q, addr_q[PAGE_BITS-1:LINE_BITS], {LINE_BITS{1'b0}}};
   assign fill_way    = way_q;
   assign chan_status = phase_status(phase_q);
   assign pos_addr    = addr_q;
   assign lines_left  = left_q;

   // VPW and OFW document the split of the address fields.
   if (VPW + OFW + LINE_BITS != AW) begin : g_bad_split
      $error("lpc_chan: address field split is inconsistent");
   end

endmodule

// File: rtl/lpc_chan_chk.sv
module lpc_chan_chk #(
   parameter int AW        = 32,
   parameter int PAW       = 32,
   parameter int CW        = 16,
   parameter int PAGE_BITS = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_wr,
   input logic                     cmd_valid,
   input logic [1:0]               cmd_op,
   input logic                     xl_req,
   input logic [AW-PAGE_BITS-1:0]  xl_vpage,
   input logic                     xl_rsp,
   input logic                     fill_req,
   input logic [PAW-1:0]           fill_addr,
   input logic                     fill_ack,
   input logic [1:0]               chan_status,
   input logic [AW-1:0]            pos_addr,
   input logic [CW-1:0]            lines_left,
   input logic                     irq_done_sec,
   input logic                     irq_done_ns,
   input logic                     irq_err
);

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_status == 2'd0 && cmd_valid && cmd_op == 2'd1 && !cfg_wr && lines_left != '0)
      |=> (xl_req && chan_status == 2'd1));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_status == 2'd0 && !cfg_wr) |=> ($stable(pos_addr) && $stable(lines_left)));

   p_xl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && !xl_rsp) |=> (xl_req && $stable(xl_vpage)));

   p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(xl_req && fill_req));

   p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

   p_fill_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (chan_status == 2'd1));

   p_retire_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_ack) |=> (lines_left == $past(lines_left) - CW'(1)));

   p_err_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (chan_status == 2'd2));

   p_done_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_done_sec, irq_done_ns}));

   p_done_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done_sec || irq_done_ns) |-> (chan_status == 2'd3));

   p_clear_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_status == 2'd2 && cmd_valid && cmd_op == 2'd3)
      |=> (chan_status == 2'd0 && !irq_err && $stable(pos_addr)));

endmodule

bind lpc_chan lpc_chan_chk #(
   .AW        (AW),
   .PAW       (PAW),
   .CW        (CW),
   .PAGE_BITS (PAGE_BITS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .cmd_valid    (cmd_valid),
   .cmd_op       (cmd_op),
   .xl_req       (xl_req),
   .xl_vpage     (xl_vpage),
   .xl_rsp       (xl_rsp),
   .fill_req     (fill_req),
   .fill_addr    (fill_addr),
   .fill_ack     (fill_ack),
   .chan_status  (chan_status),
   .pos_addr     (pos_addr),
   .lines_left   (lines_left),
   .irq_done_sec (irq_done_sec),
   .irq_done_ns  (irq_done_ns),
   .irq_err      (irq_err)
);

// File: tb/lpc_chan_test.sv
module lpc_chan_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [15:0] cfg_lines = '0;
   logic [15:0] cfg_stride = '0;
   logic [2:0]  cfg_way = '0;
   logic        cfg_done_sec = 1'b0;
   logic        cfg_err_irq_en = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic        xl_req;
   logic [19:0] xl_vpage;
   logic        xl_rsp = 1'b0;
   logic [19:0] xl_ppage;
   logic        xl_cacheable;
   logic        xl_fault;
   logic        fill_req;
   logic [31:0] fill_addr;
   logic [2:0]  fill_way;
   logic        fill_ack = 1'b0;
   logic [1:0]  chan_status;
   logic [31:0] pos_addr;
   logic [15:0] lines_left;
   logic        irq_done_sec;
   logic        irq_done_ns;
   logic        irq_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int xl_lat = 2;
   int fill_lat = 1;
   int xl_cnt = 0;
   int fill_cnt = 0;
   int xl_seen = 0;
   int fill_seen = 0;
   logic [19:0] fault_vp = 20'hFFFFF;

   always #2 clk = ~clk;

   lpc_chan uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_lines(cfg_lines), .cfg_stride(cfg_stride), .cfg_way(cfg_way),
      .cfg_done_sec(cfg_done_sec), .cfg_err_irq_en(cfg_err_irq_en),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .xl_req(xl_req),
      .xl_vpage(xl_vpage), .xl_rsp(xl_rsp), .xl_ppage(xl_ppage),
      .xl_cacheable(xl_cacheable), .xl_fault(xl_fault), .fill_req(fill_req),
      .fill_addr(fill_addr), .fill_way(fill_way), .fill_ack(fill_ack),
      .chan_status(chan_status), .pos_addr(pos_addr), .lines_left(lines_left),
      .irq_done_sec(irq_done_sec), .irq_done_ns(irq_done_ns), .irq_err(irq_err)
   );

   // Translation agent: fixed page offset; pages with bit 1 set are uncached.
   assign xl_ppage     = xl_vpage + 20'h00100;
   assign xl_cacheable = !xl_vpage[1];
   assign xl_fault     = (xl_vpage == fault_vp);

   // Behavioural reference model (phase: 0 idle, 1 translate, 2 fill, 3 skip, 4 error, 5 complete)
   int          m_ph = 0;
   logic [31:0] m_addr = '0;
   logic [15:0] m_left = '0;
   logic [15:0] m_stride = '0;
   logic [2:0]  m_way = '0;
   logic        m_sec = 1'b0, m_en = 1'b0, m_cach = 1'b0, m_stop = 1'b0;
   logic [19:0] m_pp = '0;
   logic        m_ie = 1'b0, m_ids = 1'b0, m_idn = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_ph = 0; m_addr = '0; m_left = '0; m_stride = '0; m_way = '0;
         m_sec = 0; m_en = 0; m_cach = 0; m_stop = 0; m_pp = '0;
         m_ie = 0; m_ids = 0; m_idn = 0;
      end else begin
         logic st, sp, cl, stopnow, retire;
         logic [19:0] oldpg;
         st = cmd_valid && cmd_op == 2'd1;
         sp = cmd_valid && cmd_op == 2'd2;
         cl = cmd_valid && cmd_op == 2'd3;
         stopnow = m_stop || sp;
         case (m_ph)
            0: begin
               if (st) m_ph = (m_left == 16'd0) ? 5 : 1;
               if (m_ph == 5) begin m_ids = m_sec; m_idn = !m_sec; end
               if (cfg_wr) begin
                  m_addr = cfg_addr; m_left = cfg_lines; m_stride = cfg_stride;
                  m_way = cfg_way; m_sec = cfg_done_sec; m_en = cfg_err_irq_en;
               end
            end
            1: begin
               if (xl_rsp) begin
                  if (xl_fault) begin m_ph = 4; m_ie = m_en; m_stop = 0; end
                  else if (stopnow) begin m_ph = 0; m_stop = 0; end
                  else begin m_pp = xl_ppage; m_cach = xl_cacheable; m_ph = m_cach ? 2 : 3; end
               end else if (sp) m_stop = 1;
            end
            2, 3: begin
               retire = (m_ph == 3) || fill_ack;
               if (retire) begin
                  oldpg = m_addr[31:12];
                  m_addr = m_addr + {16'd0, m_stride};
                  m_left = m_left - 16'd1;
                  if (m_left == 16'd0) begin m_ph = 5; m_ids = m_sec; m_idn = !m_sec; m_stop = 0; end
                  else if (stopnow) begin m_ph = 0; m_stop = 0; end
                  else if (m_addr[31:12] != oldpg) m_ph = 1;
               end else if (sp) m_stop = 1;
            end
            default: begin
               if (cl) begin m_ph = 0; m_ie = 0; m_ids = 0; m_idn = 0; end
            end
         endcase
      end
   end

   task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, nm, act, exp, cyc);
      end
   endtask

   function automatic logic [1:0] m_status();
      case (m_ph)
         1, 2, 3: return 2'd1;
         4:       return 2'd2;
         5:       return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   // Per-cycle comparison, then the responders drive the next inputs.
   always @(negedge clk) begin
      chk("R1", "status", 32'(chan_status), 32'(m_status()));
      chk("R7", "pos_addr", pos_addr, m_addr);
      chk("R7", "lines_left", 32'(lines_left), 32'(m_left));
      chk("R4", "xl_req", 32'(xl_req), 32'(m_ph == 1));
      if (m_ph == 1) chk("R4", "xl_vpage", 32'(xl_vpage), 32'(m_addr[31:12]));
      chk("R5", "fill_req", 32'(fill_req), 32'(m_ph == 2));
      if (m_ph == 2) begin
         chk("R5", "fill_addr", fill_addr, {m_pp, m_addr[11:6], 6'd0});
         chk("R5", "fill_way", 32'(fill_way), 32'(m_way));
      end
      chk("R9", "irq_err", 32'(irq_err), 32'(m_ie));
      chk("R10", "irq_done_sec", 32'(irq_done_sec), 32'(m_ids));
      chk("R10", "irq_done_ns", 32'(irq_done_ns), 32'(m_idn));

      if (fill_req) fill_seen++;
      if (xl_rsp) begin xl_rsp <= 1'b0; xl_cnt = 0; end
      else if (xl_req) begin
         xl_cnt++;
         if (xl_cnt >= xl_lat) begin xl_rsp <= 1'b1; xl_seen++; end
      end
      if (fill_ack) begin fill_ack <= 1'b0; fill_cnt = 0; end
      else if (fill_req) begin
         fill_cnt++;
         if (fill_cnt >= fill_lat) fill_ack <= 1'b1;
      end
   end

   task automatic summary_and_end();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         summary_and_end();
      end
   end

   task automatic issue(input logic [1:0] op);
      @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd0;
   endtask

   task automatic load(input logic [31:0] a, input logic [15:0] n, input logic [15:0] s,
                       input logic [2:0] w, input logic sec, input logic en);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_lines = n; cfg_stride = s;
      cfg_way = w; cfg_done_sec = sec; cfg_err_irq_en = en;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic wait_status(input logic [1:0] s, input string tag);
      int n = 0;
      while (chan_status != s && n < 5000) begin @(negedge clk); n++; end
      chk(tag, "reach status", 32'(chan_status), 32'(s));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1", "reset irq lines", {29'd0, irq_done_sec, irq_done_ns, irq_err}, 32'd0);
      chk("R1", "reset requests", {30'd0, xl_req, fill_req}, 32'd0);
      rst_n = 1'b1;

      // Cacheable run crossing one page boundary, stray commands while running.
      xl_seen = 0;
      load(32'h0000_0F00, 16'd8, 16'h0040, 3'd5, 1'b1, 1'b1);
      issue(2'd1);
      repeat (3) @(negedge clk);
      issue(2'd1);
      issue(2'd3);
      chk("R11", "clear while running", 32'(chan_status), 32'd1);
      wait_status(2'd3, "R10");
      chk("R4", "translations for two pages", 32'(xl_seen), 32'd2);
      chk("R7", "end position", pos_addr, 32'h0000_1100);
      chk("R10", "secure done irq", {30'd0, irq_done_sec, irq_done_ns}, 32'd2);
      issue(2'd1);
      chk("R2", "start in complete ignored", 32'(chan_status), 32'd3);
      load(32'h0000_9000, 16'd3, 16'h0040, 3'd1, 1'b0, 1'b0);
      chk("R3", "cfg in complete ignored", pos_addr, 32'h0000_1100);
      issue(2'd3);
      chk("R11", "clear to idle", 32'(chan_status), 32'd0);
      chk("R11", "clear drops irqs", {29'd0, irq_done_sec, irq_done_ns, irq_err}, 32'd0);
      chk("R11", "clear keeps position", pos_addr, 32'h0000_1100);

      // Non-cacheable pages: lines are counted off without fills.
      fill_seen = 0;
      load(32'h0000_2000, 16'd5, 16'h0400, 3'd2, 1'b0, 1'b1);
      issue(2'd1);
      wait_status(2'd3, "R6");
      chk("R6", "no fill requests", 32'(fill_seen), 32'd0);
      chk("R7", "uncached end position", pos_addr, 32'h0000_3400);
      chk("R10", "non-secure done irq", {30'd0, irq_done_sec, irq_done_ns}, 32'd1);
      issue(2'd3);

      // STOP mid-run with slow fills, then resume.
      fill_lat = 3;
      load(32'h0000_4000, 16'd10, 16'h0040, 3'd1, 1'b1, 1'b1);
      issue(2'd1);
      repeat (4) @(negedge clk);
      load(32'h0000_A000, 16'd2, 16'h0080, 3'd7, 1'b0, 1'b0);
      repeat (6) @(negedge clk);
      issue(2'd2);
      wait_status(2'd0, "R8");
      chk("R3", "cfg while running ignored", pos_addr + 32'(lines_left) * 32'h40, 32'h0000_4280);
      chk("R8", "stopped part way", 32'((lines_left > 16'd0) && (lines_left < 16'd10)), 32'd1);
      issue(2'd1);
      wait_status(2'd3, "R8");
      chk("R8", "resumed end position", pos_addr, 32'h0000_4280);
      issue(2'd3);
      fill_lat = 1;

      // Fault on the second page, with and without the error interrupt.
      fault_vp = 20'h00006;
      load(32'h0000_5F80, 16'd6, 16'h0040, 3'd0, 1'b1, 1'b1);
      issue(2'd1);
      wait_status(2'd2, "R9");
      chk("R9", "fault address kept", pos_addr, 32'h0000_6000);
      chk("R9", "lines left at fault", 32'(lines_left), 32'd4);
      chk("R9", "error irq enabled", 32'(irq_err), 32'd1);
      issue(2'd3);
      chk("R11", "clear drops error irq", 32'(irq_err), 32'd0);
      load(32'h0000_5F80, 16'd6, 16'h0040, 3'd0, 1'b1, 1'b0);
      issue(2'd1);
      wait_status(2'd2, "R9");
      chk("R9", "error irq disabled", 32'(irq_err), 32'd0);
      issue(2'd3);
      fault_vp = 20'hFFFFF;

      // Zero-length run completes at once.
      load(32'h0000_7000, 16'd0, 16'h0040, 3'd3, 1'b0, 1'b1);
      issue(2'd1);
      chk("R2", "zero lines completes", 32'(chan_status), 32'd3);
      chk("R2", "zero lines irq", 32'(irq_done_ns), 32'd1);
      issue(2'd3);

      // STOP while a translation is outstanding.
      xl_lat = 4;
      load(32'h0000_8000, 16'd3, 16'h0040, 3'd4, 1'b1, 1'b1);
      issue(2'd1);
      issue(2'd2);
      wait_status(2'd0, "R8");
      chk("R8", "stop before first line pos", pos_addr, 32'h0000_8000);
      chk("R8", "stop before first line left", 32'(lines_left), 32'd3);
      xl_lat = 2;
      issue(2'd1);
      wait_status(2'd3, "R8");
      chk("R7", "short run end", pos_addr, 32'h0000_80C0);

      repeat (3) @(negedge clk);
      summary_and_end();
   end

endmodule